// File: doc/BRIEF.md
# Extended I/O Interrupt Router

This block takes 256 level-sensitive interrupt sources and steers each one to one of four processor cores and to one of four interrupt pins on that core. Software programs an enable bit for each source, a core selector for each source and a pin selector for each group of 32 sources through a small register bus. For each core, a 256-bit status bitmap records which sources are pending there. Software acknowledges a pending source by writing 1 to its status bit.

The bus carries one access per cycle, marked by a valid strobe. An access is 1, 4 or 8 bytes wide, little-endian, and starts at any byte offset in a 0x900-byte window. Each byte lane is decoded on its own. Read data appears on a registered output in the cycle after the access. The block drives sixteen level outputs, one for each core/pin pair. Each output is high while any status bit of that core, in a group steered to that pin, is set.

Top module: `eio_router`

## Requirements
- R1: After synchronous reset, every output is 0 and every register reads back 0.
- R2: Source i is enabled by bit i%8 of the enable byte at offset 0x200 + i/8. A rising edge on an enabled source sets its status bit in its mapped core one clock later. A rising edge on a disabled source sets nothing.
- R3: The byte at offset 0x800 + i selects the core for source i. The lowest set bit of its low nibble gives core 0 to 3. A zero nibble selects core 0.
- R4: The byte at offset 0x0C0 + g selects the pin for sources 32g to 32g+31. The lowest set bit of its low nibble gives the pin. A zero nibble selects pin 0. Output bit 4*core + pin carries that pair.
- R5: The status byte b (0 to 31) of core c is at offset 0x400 + 0x100*c + b, and bit j of that byte belongs to source 8b + j. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. Offsets 0x420 to 0x4FF in each core's 0x100 span read as 0.
- R6: A falling edge on a source clears its status bit in its mapped core one clock later.
- R7: A write to the enable bitmap sets the status bit of every source whose enable goes from 0 to 1. It clears the status bit of every source whose enable goes from 1 to 0. Both take effect in the mapped core, whatever the source level.
- R8: An output stays high while at least one contributing status bit is set. It drops only after the last one is cleared.
- R9: The 32-byte table at 0x280 and the 32-byte table at 0x0A0 read back what was written and do not change any output.
- R10: bus_size 0, 1 and 2 access 1, 4 and 8 bytes, with lane k at offset addr+k carrying data bits 8k+7 to 8k. bus_size 3 accesses nothing. Unmapped offsets, including those at or above 0x900, read as 0 and ignore writes.
- R11: bus_rdata takes the read value on the clock edge that ends a read access and holds it through idle and write cycles.
- R12: When a status bit is set by its source and cleared by a bus write in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0: 1 byte, 1: 4 bytes, 2: 8 bytes, 3: none |
| bus_addr | input | 12 | Byte offset of lane 0 |
| bus_wdata | input | 64 | Write data, lane k in bits 8k+7:8k |
| bus_rdata | output | 64 | Registered read data |
| src_level | input | 256 | Source levels |
| irq_out | output | 16 | Interrupt level for core c, pin p at bit 4c+p |

## Verification
Directed cases pin down each steering decode: a zero nibble against a multi-bit nibble, separating the lowest-set-bit rule and the index-0 fallback from other encodings. Source edges are applied with the enable both on and off, and enable writes are made with the source both low and high. This separates edge-driven setting from setting driven by an enable transition. Two sources share one output so that the OR-hold can be told apart from a last-event output. A collision of a source set and a bus clear in the same cycle checks the ordering. Unaligned and oversized accesses check lane decode. A seeded random mix of map, enable, source and clear operations is compared with a bench model after every step.

// File: rtl/eio_pkg.sv
package eio_pkg;
  localparam int SRC_N  = 256;
  localparam int CORE_N = 4;
  localparam int PIN_N  = 4;
  localparam int GRP_W  = 32;
  localparam int LANE_N = 8;
  localparam int ADDR_W = 12;
  localparam int GRP_N  = SRC_N / GRP_W;
  localparam int BYTE_N = SRC_N / 8;
  localparam int OUT_N  = CORE_N * PIN_N;

  typedef enum logic [2:0] {
    RG_NONE, RG_NODE, RG_PMAP, RG_EN, RG_BNC, RG_STAT, RG_CMAP
  } rgn_e;

  // For RG_STAT, idx[6:5] is the core and idx[4:0] the byte.
  typedef struct packed {
    rgn_e       rgn;
    logic [7:0] idx;
  } dec_t;

  function automatic dec_t decode(input logic [ADDR_W:0] a);
    dec_t d;
    d.rgn = RG_NONE;
    d.idx = '0;
    if (a >= 13'h0A0 && a < 13'h0C0) begin
      d.rgn = RG_NODE; d.idx = 8'(a - 13'h0A0);
    end else if (a >= 13'h0C0 && a < 13'h0C8) begin
      d.rgn = RG_PMAP; d.idx = 8'(a - 13'h0C0);
    end else if (a >= 13'h200 && a < 13'h220) begin
      d.rgn = RG_EN; d.idx = 8'(a - 13'h200);
    end else if (a >= 13'h280 && a < 13'h2A0) begin
      d.rgn = RG_BNC; d.idx = 8'(a - 13'h280);
    end else if (a >= 13'h400 && a < 13'h800 && a[7:5] == 3'b000) begin
      d.rgn = RG_STAT; d.idx = {1'b0, a[9:8], a[4:0]};
    end else if (a >= 13'h800 && a < 13'h900) begin
      d.rgn = RG_CMAP; d.idx = a[7:0];
    end
    return d;
  endfunction

  // Lowest set bit of a selector nibble, 0 when empty.
  function automatic logic [1:0] first_set(input logic [3:0] n);
    logic [1:0] r;
    r = 2'd0;
    for (int j = 3; j >= 0; j--) if (n[j]) r = 2'(j);
    return r;
  endfunction

  function automatic logic [3:0] lane_count(input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'd1;
      2'd1:    return 4'd4;
      2'd2:    return 4'd8;
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/eio_cfg.sv
module eio_cfg
  import eio_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic [LANE_N-1:0]             lane_wr,
  input  dec_t [LANE_N-1:0]             lane_dec,
  input  logic [LANE_N-1:0][7:0]        lane_d,
  output logic [SRC_N-1:0]              en_q,
  output logic [SRC_N-1:0]              en_d,
  output logic [SRC_N-1:0][7:0]         cmap_q,
  output logic [GRP_N-1:0][7:0]         pmap_q,
  output logic [BYTE_N-1:0][7:0]        bnc_q,
  output logic [BYTE_N-1:0][7:0]        node_q
);
  always_comb begin
    en_d = en_q;
    for (int k = 0; k < LANE_N; k++)
      if (lane_wr[k] && lane_dec[k].rgn == RG_EN)
        en_d[{lane_dec[k].idx[4:0], 3'b000} +: 8] = lane_d[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      cmap_q <= '0;
      pmap_q <= '0;
      bnc_q  <= '0;
      node_q <= '0;
    end else begin
      en_q <= en_d;
      for (int k = 0; k < LANE_N; k++) begin
        if (lane_wr[k]) begin
          case (lane_dec[k].rgn)
            RG_CMAP: cmap_q[lane_dec[k].idx]      <= lane_d[k];
            RG_PMAP: pmap_q[lane_dec[k].idx[2:0]] <= lane_d[k];
            RG_BNC:  bnc_q[lane_dec[k].idx[4:0]]  <= lane_d[k];
            RG_NODE: node_q[lane_dec[k].idx[4:0]] <= lane_d[k];
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/eio_status.sv
module eio_status
  import eio_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic [SRC_N-1:0]                src_level,
  input  logic [SRC_N-1:0]                en_q,
  input  logic [SRC_N-1:0]                en_d,
  input  logic [SRC_N-1:0][3:0]           core_sel,
  input  logic [CORE_N-1:0][SRC_N-1:0]    w1c,
  output logic [CORE_N-1:0][SRC_N-1:0]    st_q
);
  logic [SRC_N-1:0]             src_q;
  logic [SRC_N-1:0]             set_ev, clr_ev;
  logic [CORE_N-1:0][SRC_N-1:0] set_c, clr_c;
  logic [SRC_N-1:0][1:0]        tgt;

  // Events: edges on enabled sources and enable transitions.
  assign set_ev = (src_level & ~src_q & en_q) | (en_d & ~en_q);
  assign clr_ev = (~src_level & src_q) | (en_q & ~en_d);

  always_comb begin
    for (int i = 0; i < SRC_N; i++) tgt[i] = first_set(core_sel[i]);
    for (int c = 0; c < CORE_N; c++)
      for (int i = 0; i < SRC_N; i++) begin
        set_c[c][i] = set_ev[i] && (tgt[i] == 2'(c));
        clr_c[c][i] = clr_ev[i] && (tgt[i] == 2'(c));
      end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      st_q  <= '0;
    end else begin
      src_q <= src_level;
      for (int c = 0; c < CORE_N; c++)
        st_q[c] <= (st_q[c] & ~(w1c[c] | clr_c[c])) | set_c[c];
    end
  end

  for (genvar c = 0; c < CORE_N; c++) begin : g_chk
    // R2 R7 R12
    set_lands_chk: assert property (@(posedge clk) disable iff (rst)
      (set_c[c] != '0) |=> ((st_q[c] & $past(set_c[c])) == $past(set_c[c])));
    // R5
    w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
      ((w1c[c] & ~set_c[c]) != '0) |=> ((st_q[c] & $past(w1c[c] & ~set_c[c])) == '0));
  end

  // R2
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (src_level == src_q && en_d == en_q && w1c == '0) |=> $stable(st_q));
endmodule

// File: rtl/eio_pin_merge.sv
module eio_pin_merge
  import eio_pkg::*;
(
  input  logic [CORE_N-1:0][SRC_N-1:0] st_q,
  input  logic [GRP_N-1:0][3:0]        pin_sel,
  output logic [OUT_N-1:0]             irq_out
);
  logic [PIN_N-1:0][SRC_N-1:0] pin_mask;

  always_comb begin
    for (int p = 0; p < PIN_N; p++)
      for (int i = 0; i < SRC_N; i++)
        pin_mask[p][i] = (first_set(pin_sel[i / GRP_W]) == 2'(p));
  end

  for (genvar c = 0; c < CORE_N; c++) begin : g_core
    for (genvar p = 0; p < PIN_N; p++) begin : g_pin
      assign irq_out[c*PIN_N + p] = |(st_q[c] & pin_mask[p]);
    end
  end
endmodule

// File: rtl/eio_router.sv
module eio_router
  import eio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [11:0]       bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  input  logic [255:0]      src_level,
  output logic [15:0]       irq_out
);
  logic [LANE_N-1:0]            lane_on, lane_wr;
  dec_t [LANE_N-1:0]            lane_dec;
  logic [LANE_N-1:0][7:0]       lane_d;
  logic [SRC_N-1:0]             en_q, en_d;
  logic [SRC_N-1:0][7:0]        cmap_q;
  logic [GRP_N-1:0][7:0]        pmap_q;
  logic [BYTE_N-1:0][7:0]       bnc_q, node_q;
  logic [SRC_N-1:0][3:0]        core_sel;
  logic [GRP_N-1:0][3:0]        pin_sel;
  logic [CORE_N-1:0][SRC_N-1:0] w1c, st_q;
  logic [63:0]                  rd_d;

  always_comb begin
    for (int k = 0; k < LANE_N; k++) begin
      lane_on[k]  = bus_valid && (4'(k) < lane_count(bus_size));
      lane_wr[k]  = lane_on[k] && bus_we;
      lane_dec[k] = decode({1'b0, bus_addr} + 13'(k));
      lane_d[k]   = bus_wdata[k*8 +: 8];
    end
    for (int i = 0; i < SRC_N; i++) core_sel[i] = cmap_q[i][3:0];
    for (int g = 0; g < GRP_N; g++) pin_sel[g] = pmap_q[g][3:0];
    w1c = '0;
    for (int k = 0; k < LANE_N; k++)
      if (lane_wr[k] && lane_dec[k].rgn == RG_STAT)
        w1c[lane_dec[k].idx[6:5]][{lane_dec[k].idx[4:0], 3'b000} +: 8] = lane_d[k];
  end

  eio_cfg u_cfg (
    .clk(clk), .rst(rst), .lane_wr(lane_wr), .lane_dec(lane_dec), .lane_d(lane_d),
    .en_q(en_q), .en_d(en_d), .cmap_q(cmap_q), .pmap_q(pmap_q),
    .bnc_q(bnc_q), .node_q(node_q)
  );

  eio_status u_status (
    .clk(clk), .rst(rst), .src_level(src_level), .en_q(en_q), .en_d(en_d),
    .core_sel(core_sel), .w1c(w1c), .st_q(st_q)
  );

  eio_pin_merge u_merge (
    .st_q(st_q), .pin_sel(pin_sel), .irq_out(irq_out)
  );

  always_comb begin
    rd_d = '0;
    for (int k = 0; k < LANE_N; k++) begin
      if (lane_on[k]) begin
        case (lane_dec[k].rgn)
          RG_NODE: rd_d[k*8 +: 8] = node_q[lane_dec[k].idx[4:0]];
          RG_PMAP: rd_d[k*8 +: 8] = pmap_q[lane_dec[k].idx[2:0]];
          RG_EN:   rd_d[k*8 +: 8] = en_q[{lane_dec[k].idx[4:0], 3'b000} +: 8];
          RG_BNC:  rd_d[k*8 +: 8] = bnc_q[lane_dec[k].idx[4:0]];
          RG_STAT: rd_d[k*8 +: 8] =
                     st_q[lane_dec[k].idx[6:5]][{lane_dec[k].idx[4:0], 3'b000} +: 8];
          RG_CMAP: rd_d[k*8 +: 8] = cmap_q[lane_dec[k].idx];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_valid && !bus_we) bus_rdata <= rd_d;
  end

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == '0) |-> (irq_out == '0));
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_we) |=> $stable(bus_rdata));
endmodule

// File: tb/test_eio_router.sv
`timescale 1ns/1ps
module test_eio_router;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_valid = 1'b0;
  logic         bus_we = 1'b0;
  logic [1:0]   bus_size = 2'd0;
  logic [11:0]  bus_addr = '0;
  logic [63:0]  bus_wdata = '0;
  logic [63:0]  bus_rdata;
  logic [255:0] src_level = '0;
  logic [15:0]  irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [255:0] m_en = '0;
  logic [255:0] m_src = '0;
  logic [7:0]   m_cmap [256];
  logic [7:0]   m_pmap [8];
  logic [7:0]   m_bnc [32];
  logic [7:0]   m_node [32];
  logic [255:0] m_st [4];

  always #2 clk = ~clk;

  eio_router i_eio_router (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_level(src_level), .irq_out(irq_out)
  );

  function automatic int low4(input logic [7:0] b);
    for (int j = 0; j < 4; j++) if (b[j]) return j;
    return 0;
  endfunction

  function automatic int nb(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 4 : (sz == 2'd2) ? 8 : 0;
  endfunction

  function automatic logic [15:0] exp_irq();
    logic [15:0] r = '0;
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 256; i++)
        if (m_st[c][i]) r[c*4 + low4(m_pmap[i/32])] = 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] exp_byte(input int a);
    if (a >= 'hA0 && a < 'hC0) return m_node[a - 'hA0];
    if (a >= 'hC0 && a < 'hC8) return m_pmap[a - 'hC0];
    if (a >= 'h200 && a < 'h220) return m_en[(a - 'h200)*8 +: 8];
    if (a >= 'h280 && a < 'h2A0) return m_bnc[a - 'h280];
    if (a >= 'h400 && a < 'h800 && ((a - 'h400) % 256) < 32)
      return m_st[(a - 'h400)/256][((a - 'h400) % 256)*8 +: 8];
    if (a >= 'h800 && a < 'h900) return m_cmap[a - 'h800];
    return 8'h00;
  endfunction

  function automatic logic [63:0] exp_rd(input int a, input logic [1:0] sz);
    logic [63:0] r = '0;
    for (int k = 0; k < nb(sz); k++) r[k*8 +: 8] = exp_byte(a + k);
    return r;
  endfunction

  function automatic void model_wr(input int a0, input logic [1:0] sz, input logic [63:0] d);
    for (int k = 0; k < nb(sz); k++) begin
      int a = a0 + k;
      logic [7:0] v = d[k*8 +: 8];
      if (a >= 'hA0 && a < 'hC0) m_node[a - 'hA0] = v;
      else if (a >= 'hC0 && a < 'hC8) m_pmap[a - 'hC0] = v;
      else if (a >= 'h200 && a < 'h220) begin
        for (int j = 0; j < 8; j++) begin
          int s = (a - 'h200)*8 + j;
          if (m_en[s] != v[j]) m_st[low4(m_cmap[s])][s] = v[j];
          m_en[s] = v[j];
        end
      end
      else if (a >= 'h280 && a < 'h2A0) m_bnc[a - 'h280] = v;
      else if (a >= 'h400 && a < 'h800 && ((a - 'h400) % 256) < 32)
        m_st[(a - 'h400)/256][((a - 'h400) % 256)*8 +: 8] &= ~v;
      else if (a >= 'h800 && a < 'h900) m_cmap[a - 'h800] = v;
    end
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit we, input logic [1:0] sz, input int a,
                     input logic [63:0] d, output logic [63:0] r);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_size = sz; bus_addr = 12'(a); bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
    r = bus_rdata;
    if (we) model_wr(a, sz, d);
  endtask

  task automatic wr(input logic [1:0] sz, input int a, input logic [63:0] d);
    logic [63:0] r;
    bus(1'b1, sz, a, d, r);
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] sz, input int a);
    logic [63:0] r;
    bus(1'b0, sz, a, 64'h0, r);
    chk(tag, r, exp_rd(a, sz));
  endtask

  task automatic drive_src(input logic [255:0] v);
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      if (v[i] && !m_src[i] && m_en[i]) m_st[low4(m_cmap[i])][i] = 1'b1;
      if (!v[i] && m_src[i]) m_st[low4(m_cmap[i])][i] = 1'b0;
    end
    m_src = v;
    src_level = v;
    @(negedge clk);
  endtask

  task automatic set_one(input int i, input bit lvl);
    logic [255:0] v = m_src;
    v[i] = lvl;
    drive_src(v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] r, held;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 256; i++) m_cmap[i] = 8'h00;
    for (int i = 0; i < 8; i++) m_pmap[i] = 8'h00;
    for (int i = 0; i < 32; i++) begin m_bnc[i] = 8'h00; m_node[i] = 8'h00; end
    for (int c = 0; c < 4; c++) m_st[c] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 64'(irq_out), 64'h0);
    rd_chk("R1 enable", 2'd2, 'h200);
    rd_chk("R1 coremap", 2'd2, 'h800);
    rd_chk("R1 pinmap", 2'd2, 'h0C0);
    rd_chk("R1 status", 2'd2, 'h400);

    // R3 R4 zero nibbles fall back to core 0 pin 0
    wr(2'd0, 'h200, 64'h20);
    chk("R7 enable-on sets", 64'(irq_out), 64'h1);
    wr(2'd0, 'h400, 64'h20);
    set_one(5, 1'b1);
    chk("R3 R4 default route", 64'(irq_out), 64'(exp_irq()));
    chk("R2 enabled rise", 64'(irq_out), 64'h1);

    // R3 R4 lowest set bit: core nibble 0x6 -> core 1, pin nibble 0xC -> pin 2
    wr(2'd0, 'h828, 64'h06);
    wr(2'd0, 'h0C1, 64'h0C);
    wr(2'd0, 'h205, 64'h01);
    wr(2'd0, 'h505, 64'h01);
    set_one(40, 1'b1);
    chk("R3 R4 mapped route", 64'(irq_out), 64'h41);

    // R2 rising while disabled sets nothing
    set_one(70, 1'b1);
    chk("R2 disabled rise irq", 64'(irq_out), 64'h41);
    rd_chk("R2 disabled rise status", 2'd0, 'h408);

    // R5 writing zero does nothing, writing one clears
    wr(2'd0, 'h400, 64'h00);
    chk("R5 zero write", 64'(irq_out), 64'h41);
    wr(2'd0, 'h400, 64'h20);
    chk("R5 one clears", 64'(irq_out), 64'h40);
    rd_chk("R5 reserved status", 2'd0, 'h420);

    // R6 falling edge clears
    set_one(5, 1'b0);
    set_one(5, 1'b1);
    chk("R6 re-rise sets", 64'(irq_out), 64'h41);
    set_one(5, 1'b0);
    chk("R6 fall clears", 64'(irq_out), 64'h40);

    // R7 disable clears
    wr(2'd0, 'h205, 64'h00);
    chk("R7 disable clears", 64'(irq_out), 64'h00);

    // R8 two sources sharing core 0 pin 0
    wr(2'd0, 'h200, 64'h0C);
    chk("R8 both up", 64'(irq_out), 64'h01);
    wr(2'd0, 'h400, 64'h04);
    chk("R8 one left holds", 64'(irq_out), 64'h01);
    wr(2'd0, 'h400, 64'h08);
    chk("R8 last cleared drops", 64'(irq_out), 64'h00);

    // R9 storage-only tables
    wr(2'd2, 'h280, 64'hFFEE_DDCC_BBAA_9988);
    wr(2'd1, 'h0A4, 64'h0000_0000_1234_5678);
    rd_chk("R9 bounce", 2'd2, 'h280);
    rd_chk("R9 node", 2'd1, 'h0A4);
    chk("R9 no effect", 64'(irq_out), 64'h00);

    // R10 unaligned 4-byte write, unmapped, size 3, window end
    wr(2'd1, 'h0C3, 64'h0000_0000_0403_0201);
    rd_chk("R10 lane order", 2'd2, 'h0C0);
    wr(2'd2, 'h300, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk("R10 unmapped", 2'd2, 'h300);
    wr(2'd3, 'h210, 64'hFF);
    rd_chk("R10 size3 write", 2'd0, 'h210);
    wr(2'd2, 'h8F8, 64'h8877_6655_4433_2211);
    rd_chk("R10 window end", 2'd2, 'h8FC);
    wr(2'd2, 'h8F8, 64'h0);
    wr(2'd1, 'h0C0, 64'h0);
    wr(2'd0, 'h0C4, 64'h0);

    // R11 read value holds through idle and writes
    bus(1'b0, 2'd2, 'h280, 64'h0, held);
    repeat (3) @(negedge clk);
    chk("R11 idle hold", bus_rdata, held);
    wr(2'd0, 'h2A0, 64'h55);
    chk("R11 write hold", bus_rdata, held);

    // R12 set and clear collide: set wins
    wr(2'd0, 'h212, 64'h40);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_size = 2'd0; bus_addr = 12'h412; bus_wdata = 64'h40;
    src_level[150] = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
    m_src[150] = 1'b1;
    rd_chk("R12 set wins", 2'd0, 'h412);
    chk("R12 irq", 64'(irq_out), 64'(exp_irq()));

    // Random mix against the model (R2 R3 R4 R5 R6 R7 R8)
    for (int it = 0; it < 300; it++) begin
      int op = int'($urandom_range(0, 4));
      int c = int'($urandom_range(0, 3));
      case (op)
        0: wr(2'd0, 'h200 + int'($urandom_range(0, 31)), 64'($urandom));
        1: wr(2'd0, 'h800 + int'($urandom_range(0, 255)), 64'($urandom));
        2: wr(2'd0, 'h0C0 + int'($urandom_range(0, 7)), 64'($urandom));
        3: begin
          logic [255:0] v = m_src;
          v[$urandom_range(0, 255)] ^= 1'b1;
          v[$urandom_range(0, 255)] ^= 1'b1;
          drive_src(v);
        end
        default: wr(2'd0, 'h400 + c*'h100 + int'($urandom_range(0, 31)), 64'($urandom));
      endcase
      chk("R8 random irq", 64'(irq_out), 64'(exp_irq()));
      rd_chk("R5 random status", 2'd2, 'h400 + c*'h100 + 8*int'($urandom_range(0, 3)));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule